// File: doc/BRIEF.md
# Low-Power Mode Controller with Wake Timer

This block sequences the power states of a small processor core. A one-cycle sleep request from the core sends the controller into one of two low-power states. A configuration bit, set through a simple write port, picks the state. In light sleep the clock keeps running, and any external interrupt brings the core back on the next clock. In deep standby the controller raises an oscillator-stop output and a clock-gate output. An external interrupt then starts a settle wait, and the core and peripherals stay stalled until the oscillator has had time to stabilise.

The settle length comes from a 3-bit delay code held next to the mode bit. The code-to-length mapping is not monotonic, and one code value is illegal. For the illegal value the controller raises an error flag and falls back to the longest wait. A 2-bit status output shows the current state, so the wait can be measured cycle by cycle. The parameter `DELAY_SHIFT` divides every settle length by 2^DELAY_SHIFT. The default of 0 gives the full lengths.

Top module: `lpm_ctrl`

## Requirements
- R1: After a synchronous reset: status is 00 (normal), the mode bit and the delay code read 0, and `code_err`, `core_stall`, `osc_stop` and `clk_gate_off` are all low.
- R2: In normal state with the mode bit at 0, a sleep request moves status to 01 (light sleep) on the next clock, and `osc_stop` stays low.
- R3: In normal state with the mode bit at 1, a sleep request moves status to 10 (deep standby) on the next clock. While status is 10, `osc_stop` and `clk_gate_off` are both high.
- R4: In light sleep, an external interrupt returns status to 00 on the next clock, with no settle state in between.
- R5: In deep standby, an external interrupt moves status to 11 (settling) on the next clock, and `osc_stop` and `clk_gate_off` are low from that cycle on.
- R6: Status stays 11 for exactly N clocks, then returns to 00. N is set by the delay code and divided by 2^DELAY_SHIFT:
  - code 000: 8,192
  - code 001: 16,384
  - code 010: 32,768
  - code 011: 65,536
  - code 100: 131,072
  - code 101: 262,144
  - code 110: 1,024
- R7: Delay code 111 drives `code_err` high while it is held. A settle wait started under code 111 lasts 262,144 (divided by 2^DELAY_SHIFT) clocks.
- R8: A write with `cfg_we` high loads the mode bit and the delay code, and they read back on the next clock. Without a write they keep their value, so the mode bit is still 1 after a return from deep standby. Writing 0 clears it.
- R9: `core_stall` is high in every state except normal.
- R10: A sleep request is ignored outside normal state, and an external interrupt is ignored in normal state. Status is unchanged on the next clock in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| cfg_we | input | 1 | Write strobe for the mode bit and the delay code |
| cfg_deep_wr | input | 1 | Mode bit to write: 1 selects deep standby |
| cfg_code_wr | input | 3 | Delay code to write |
| ext_irq | input | 1 | External interrupt (wake source) |
| cfg_deep | output | 1 | Current mode bit |
| cfg_code | output | 3 | Current delay code |
| code_err | output | 1 | High while the delay code is the illegal value 111 |
| core_stall | output | 1 | Core and peripherals held |
| osc_stop | output | 1 | Oscillator stop request |
| clk_gate_off | output | 1 | Clock gated off |
| pm_status | output | 2 | 00 normal, 01 light sleep, 10 deep standby, 11 settling |

## Verification
Every state change, every configuration write and every output change is due exactly one clock after the input that causes it. No output depends on an input through combinational logic only. The bench drives inputs on the falling edge and keeps a behavioural model that it advances on the rising edge. It compares the model with the outputs on the next falling edge, so each result is checked in the cycle it is due. For each delay code, the bench also counts the falling edges with status 11, starting from the first falling edge after the wake interrupt. It compares that count with the expected length, which checks the exact settle length.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        PM_RUN    = 2'b00,
        PM_NAP    = 2'b01,
        PM_DEEP   = 2'b10,
        PM_SETTLE = 2'b11
    } pm_state_e;

    typedef struct packed {
        logic       deep;
        logic [2:0] code;
    } pm_cfg_t;

    localparam int         MAX_EXP  = 18;
    localparam logic [2:0] BAD_CODE = 3'b111;

    // log2 of the settle length for each delay code; illegal code falls back to the longest
    function automatic int wake_exp(input logic [2:0] code);
        case (code)
            3'd0:    return 13;
            3'd1:    return 14;
            3'd2:    return 15;
            3'd3:    return 16;
            3'd4:    return 17;
            3'd5:    return 18;
            3'd6:    return 10;
            default: return MAX_EXP;
        endcase
    endfunction

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
    import lpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  pm_cfg_t wr,
    output pm_cfg_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wr;
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R8
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wr)));

endmodule

// File: rtl/lpm_delay_dec.sv
module lpm_delay_dec
    import lpm_pkg::*;
#(
    parameter int DELAY_SHIFT = 0,
    parameter int CNT_W       = MAX_EXP - DELAY_SHIFT
) (
    input  logic [2:0]       code,
    output logic [CNT_W-1:0] load_val,
    output logic             err
);

    logic [CNT_W:0] full;
    logic [CNT_W:0] minus_one;

    always_comb begin
        full      = {{CNT_W{1'b0}}, 1'b1} << (wake_exp(code) - DELAY_SHIFT);
        minus_one = full - {{CNT_W{1'b0}}, 1'b1};
        load_val  = minus_one[CNT_W-1:0];
        err       = (code == BAD_CODE);
    end

endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int DELAY_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       cfg_we,
    input  logic       cfg_deep_wr,
    input  logic [2:0] cfg_code_wr,
    input  logic       ext_irq,
    output logic       cfg_deep,
    output logic [2:0] cfg_code,
    output logic       code_err,
    output logic       core_stall,
    output logic       osc_stop,
    output logic       clk_gate_off,
    output logic [1:0] pm_status
);

    localparam int CNT_W = MAX_EXP - DELAY_SHIFT;

    pm_cfg_t          cfg_q;
    pm_cfg_t          cfg_wr;
    pm_state_e        state_q, state_d;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             cnt_load;
    logic             dec_err;

    assign cfg_wr = '{deep: cfg_deep_wr, code: cfg_code_wr};

    lpm_cfg_reg u_cfg (
        .clk (clk),
        .rst (rst),
        .we  (cfg_we),
        .wr  (cfg_wr),
        .q   (cfg_q)
    );

    lpm_delay_dec #(.DELAY_SHIFT(DELAY_SHIFT), .CNT_W(CNT_W)) u_dec (
        .code     (cfg_q.code),
        .load_val (load_val),
        .err      (dec_err)
    );

    lpm_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (load_val),
        .run      (state_q == PM_SETTLE),
        .cnt      (cnt),
        .zero     (cnt_zero)
    );

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        case (state_q)
            PM_RUN:    if (sleep_req) state_d = cfg_q.deep ? PM_DEEP : PM_NAP;
            PM_NAP:    if (ext_irq)   state_d = PM_RUN;
            PM_DEEP:   if (ext_irq) begin
                           state_d  = PM_SETTLE;
                           cnt_load = 1'b1;
                       end
            PM_SETTLE: if (cnt_zero)  state_d = PM_RUN;
            default:   state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PM_RUN;
        else
            state_q <= state_d;
    end

    assign cfg_deep     = cfg_q.deep;
    assign cfg_code     = cfg_q.code;
    assign code_err     = dec_err;
    assign core_stall   = (state_q != PM_RUN);
    assign osc_stop     = (state_q == PM_DEEP);
    assign clk_gate_off = (state_q == PM_DEEP);
    assign pm_status    = state_q;

    // R2
    nap_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && sleep_req && !cfg_deep) |=> (pm_status == 2'b01 && !osc_stop));

    // R3
    deep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && sleep_req && cfg_deep) |=> (osc_stop && clk_gate_off));

    // R4
    nap_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_NAP && ext_irq) |=> (pm_status == 2'b00));

    // R5
    deep_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_DEEP && ext_irq) |=> (pm_status == 2'b11 && !osc_stop && !clk_gate_off));

    // R7
    bad_code_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_DEEP && ext_irq && cfg_code == BAD_CODE) |=> (cnt == {CNT_W{1'b1}}));

    // R6
    settle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_SETTLE && cnt != '0) |=> (pm_status == 2'b11));

    // R10
    run_irq_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && !sleep_req) |=> (pm_status == 2'b00));

endmodule

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;

    localparam int SHIFT = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_deep_wr = 1'b0;
    logic [2:0] cfg_code_wr = 3'd0;
    logic       ext_irq = 1'b0;
    logic       cfg_deep;
    logic [2:0] cfg_code;
    logic       code_err;
    logic       core_stall;
    logic       osc_stop;
    logic       clk_gate_off;
    logic [1:0] pm_status;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    lpm_ctrl #(.DELAY_SHIFT(SHIFT)) u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .cfg_we(cfg_we),
        .cfg_deep_wr(cfg_deep_wr), .cfg_code_wr(cfg_code_wr), .ext_irq(ext_irq),
        .cfg_deep(cfg_deep), .cfg_code(cfg_code), .code_err(code_err),
        .core_stall(core_stall), .osc_stop(osc_stop), .clk_gate_off(clk_gate_off),
        .pm_status(pm_status)
    );

    always #10 clk = ~clk;

    function automatic int exp_len(input int code);
        int base;
        case (code)
            0: base = 8192;
            1: base = 16384;
            2: base = 32768;
            3: base = 65536;
            4: base = 131072;
            5: base = 262144;
            6: base = 1024;
            default: base = 262144;
        endcase
        return base >> SHIFT;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 normal, 1 light sleep, 2 standby, 3 settling
    int m_state = 0;
    int m_mode  = 0;
    int m_code  = 0;
    int m_left  = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_mode = 0; m_code = 0; m_left = 0;
        end else begin
            if (m_state == 0) begin
                if (sleep_req) m_state = (m_mode != 0) ? 2 : 1;
            end else if (m_state == 1) begin
                if (ext_irq) m_state = 0;
            end else if (m_state == 2) begin
                if (ext_irq) begin m_state = 3; m_left = exp_len(m_code); end
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) m_state = 0;
            end
            if (cfg_we) begin m_mode = int'(cfg_deep_wr); m_code = int'(cfg_code_wr); end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 status", int'(pm_status), m_state);
            chk("R9 core_stall", int'(core_stall), (m_state != 0) ? 1 : 0);
            chk("R3 osc_stop", int'(osc_stop), (m_state == 2) ? 1 : 0);
            chk("R5 clk_gate_off", int'(clk_gate_off), (m_state == 2) ? 1 : 0);
            chk("R8 mode bit", int'(cfg_deep), m_mode);
            chk("R8 delay code", int'(cfg_code), m_code);
            chk("R7 code_err", int'(code_err), (m_code == 7) ? 1 : 0);
        end
    end

    task automatic write_cfg(input logic deep, input logic [2:0] code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_deep_wr = deep; cfg_code_wr = code;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_sleep;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_irq;
        @(negedge clk); ext_irq = 1'b1;
        @(negedge clk); ext_irq = 1'b0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(pm_status), 0);
        chk("R1 outputs", int'({cfg_deep, cfg_code, code_err, core_stall, osc_stop, clk_gate_off}), 0);

        // R10 interrupt in normal state ignored
        pulse_irq();
        chk("R10 irq in normal", int'(pm_status), 0);

        // R2 light sleep, R10 sleep request ignored in sleep, R4 wake
        pulse_sleep();
        chk("R2 light sleep", int'(pm_status), 1);
        chk("R2 osc_stop low", int'(osc_stop), 0);
        pulse_sleep();
        chk("R10 sleep in sleep", int'(pm_status), 1);
        pulse_irq();
        chk("R4 wake from sleep", int'(pm_status), 0);

        for (int c = 0; c < 8; c++) begin
            int n;
            write_cfg(1'b1, 3'(c));
            chk("R7 code_err level", int'(code_err), (c == 7) ? 1 : 0);
            pulse_sleep();
            chk("R3 standby", int'(pm_status), 2);
            chk("R3 osc and gate", int'({osc_stop, clk_gate_off}), 3);
            pulse_sleep();
            chk("R10 sleep in standby", int'(pm_status), 2);
            pulse_irq();
            chk("R5 settling", int'(pm_status), 3);
            chk("R5 osc and gate low", int'({osc_stop, clk_gate_off}), 0);
            n = 0;
            while (pm_status == 2'b11) begin
                n++;
                if (n == 3) sleep_req = 1'b1;   // R10 request during settling
                if (n == 4) sleep_req = 1'b0;
                @(negedge clk);
            end
            chk((c == 7) ? "R7 fallback length" : "R6 settle length", n, exp_len(c));
            chk("R8 mode bit kept", int'(cfg_deep), 1);
        end

        write_cfg(1'b0, 3'd6);
        chk("R8 mode cleared", int'(cfg_deep), 0);
        pulse_sleep();
        chk("R2 sleep after clear", int'(pm_status), 1);
        pulse_irq();
        chk("R4 back to normal", int'(pm_status), 0);
        @(negedge clk);
        finish_run();
    end

endmodule